// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache Controller

This block is a small word-addressed cache between a processor port and a slower backing memory. Each word address splits into a set index in its low bits and a tag in the rest. Each set has two ways. A way holds a valid flag, a tag, a dirty flag and one data word. One tag comparator per way checks both ways of the selected set in the same cycle. The processor issues one request at a time. The controller stalls it until the access is complete, then raises a one-cycle completion pulse together with the read data and a hit flag.

On a miss, the controller fetches the word over a request/acknowledge memory port. The word goes into the lowest-numbered empty way of the set. If both ways are full, it replaces the least recently used way, which one recency bit per set tracks. A parameter selects the write policy. In write-through mode, every write also goes to memory. In write-back mode, a write marks the way dirty, and a dirty victim is written out before the new word is fetched. A write miss allocates the word in the cache.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset, no way in any set is valid, dirty, or marked by the recency bit, and `cpu_done` and `mem_req` are low. The first access to any address is therefore a miss.
- R2: An access hits only when a valid way of the indexed set (index = address bit 0 by default) holds the request tag. A read hit returns the stored word and makes no memory request.
- R3: On a read miss, the controller reads the word at the request address from memory and returns it with `cpu_hit` low.
- R4: On a miss, a set with an empty way fills way 0 first, then way 1.
- R5: When both ways are valid, the miss replaces the way not used most recently. Read hits, write hits and fills all count as a use.
- R6: From reset with two sets of two ways, reads of words 0, 2, 0, 4, 2 give miss, miss, hit, miss, miss.
- R7: From reset, reads of words 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 give exactly two hits: the third and sixth accesses.
- R8: In write-through mode (`WRITE_BACK`=0), every write, hit or miss, updates the backing memory word before `cpu_done`.
- R9: In write-back mode (`WRITE_BACK`=1), a write hit leaves memory unchanged and marks the way dirty. A dirty victim is written to its own address in memory, and that memory write comes before the fill read.
- R10: Evicting a clean victim makes only the fill read, with no memory write.
- R11: `cpu_done` is high for exactly one cycle per request. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. A miss completes only in the cycle after an acknowledge.
- R12: A write miss installs the written word, so a following read of that address hits and returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken when the controller is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_hit | output | 1 | Access hit in the cache, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is a dirty victim in write-back mode. It needs a set with both ways filled, at least one of them written, and the recency bit pointing at that written way, all before a third tag maps to the set. The bench gets there with a write miss to word 0, a write to word 2, and then a read of word 4. It then checks that the memory model saw a write of the old word 0 before the fill read. A reference model of tags, recency, dirty flags and memory contents predicts the hit flag and data of every access in both write modes.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU
  } cc_state_e;
endpackage

// File: rtl/cache2w_tagcmp.sv
module cache2w_tagcmp #(
  parameter int TAG_W = 7,
  parameter int WAYS  = 2
) (
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]      req_tag,
  output logic [WAYS-1:0]       hit_vec
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_vld[g] && (way_tag[g*TAG_W +: TAG_W] == req_tag);
  end
endmodule

// File: rtl/cache2w_victim.sv
module cache2w_victim (
  input  logic [1:0] way_vld,
  input  logic       lru_bit,
  output logic       victim
);
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = lru_bit;
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SETS       = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  cc_state_e         state_q;
  logic [ADDR_W-1:0] q_addr;
  logic              q_we;
  logic [DATA_W-1:0] q_wdata;
  logic              q_way;
  logic              q_hit;

  logic [SETS-1:0]   vld_q [WAYS];
  logic [SETS-1:0]   drt_q [WAYS];
  logic [SETS-1:0]   lru_q;
  logic [TAG_W-1:0]  tag_mem  [WAYS][SETS];
  logic [DATA_W-1:0] data_mem [WAYS][SETS];

  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     req_tag;
  logic [WAYS-1:0]      set_vld;
  logic [WAYS*TAG_W-1:0] set_tag;
  logic [WAYS-1:0]      hit_vec;
  logic                 any_hit;
  logic                 hit_way;
  logic                 victim;

  assign idx     = q_addr[IDX_W-1:0];
  assign req_tag = q_addr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign set_vld[w]                 = vld_q[w][idx];
    assign set_tag[w*TAG_W +: TAG_W] = tag_mem[w][idx];
  end

  cache2w_tagcmp #(.TAG_W(TAG_W), .WAYS(WAYS)) u_cmp (
    .way_vld (set_vld),
    .way_tag (set_tag),
    .req_tag (req_tag),
    .hit_vec (hit_vec)
  );

  cache2w_victim u_vic (
    .way_vld (set_vld),
    .lru_bit (lru_q[idx]),
    .victim  (victim)
  );

  assign any_hit = |hit_vec;
  assign hit_way = hit_vec[1];

  // Array write port
  logic              arr_we;
  logic              tag_we;
  logic              arr_way;
  logic [DATA_W-1:0] arr_data;

  always_comb begin
    arr_we   = 1'b0;
    tag_we   = 1'b0;
    arr_way  = hit_way;
    arr_data = q_wdata;
    if (state_q == ST_LOOK && any_hit && q_we) begin
      arr_we = 1'b1;
    end else if (state_q == ST_FILL && mem_ack) begin
      arr_we   = 1'b1;
      tag_we   = 1'b1;
      arr_way  = q_way;
      arr_data = q_we ? q_wdata : mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) data_mem[arr_way][idx] <= arr_data;
    if (tag_we) tag_mem[arr_way][idx]  <= req_tag;
  end

  // Status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w] <= '0;
        drt_q[w] <= '0;
      end
      lru_q <= '0;
    end else if (state_q == ST_LOOK && any_hit) begin
      lru_q[idx] <= ~hit_way;
      if (q_we && WRITE_BACK) drt_q[hit_way][idx] <= 1'b1;
    end else if (state_q == ST_FILL && mem_ack) begin
      vld_q[q_way][idx] <= 1'b1;
      drt_q[q_way][idx] <= WRITE_BACK && q_we;
      lru_q[idx]        <= ~q_way;
    end
  end

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      q_addr    <= '0;
      q_we      <= 1'b0;
      q_wdata   <= '0;
      q_way     <= 1'b0;
      q_hit     <= 1'b0;
      cpu_rdata <= '0;
      cpu_hit   <= 1'b0;
      cpu_done  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req) begin
          q_addr  <= cpu_addr;
          q_we    <= cpu_we;
          q_wdata <= cpu_wdata;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (any_hit) begin
          if (!q_we) begin
            cpu_rdata <= data_mem[hit_way][idx];
            cpu_hit   <= 1'b1;
            cpu_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (WRITE_BACK) begin
            cpu_rdata <= q_wdata;
            cpu_hit   <= 1'b1;
            cpu_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            q_hit     <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= q_addr;
            mem_wdata <= q_wdata;
            state_q   <= ST_WTHRU;
          end
        end else begin
          q_way <= victim;
          if (WRITE_BACK && vld_q[victim][idx] && drt_q[victim][idx]) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {tag_mem[victim][idx], idx};
            mem_wdata <= data_mem[victim][idx];
            state_q   <= ST_EVICT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= q_addr;
            state_q  <= ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack) begin
          mem_we   <= 1'b0;
          mem_addr <= q_addr;
          state_q  <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          if (q_we && !WRITE_BACK) begin
            q_hit     <= 1'b0;
            mem_we    <= 1'b1;
            mem_addr  <= q_addr;
            mem_wdata <= q_wdata;
            state_q   <= ST_WTHRU;
          end else begin
            mem_req   <= 1'b0;
            cpu_rdata <= q_we ? q_wdata : mem_rdata;
            cpu_hit   <= 1'b0;
            cpu_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_WTHRU: if (mem_ack) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          cpu_rdata <= q_wdata;
          cpu_hit   <= q_hit;
          cpu_done  <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_done && !mem_req));

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  // R11: memory request held stable until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R11: a miss only completes right after a memory acknowledge
  a_r11_miss_after_ack: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && !cpu_hit) |-> $past(mem_ack));

  // R2: completion never overlaps an open memory request
  a_r2_done_idle_mem: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);
endmodule

bind cache2w_ctrl cache2w_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cpu_done (cpu_done),
  .cpu_hit  (cpu_hit),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr)
);

// File: tb/cache2w_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache2w_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cpu_req  [2];
  logic          cpu_we   [2];
  logic [AW-1:0] cpu_addr [2];
  logic [DW-1:0] cpu_wdata[2];
  logic [DW-1:0] cpu_rdata[2];
  logic          cpu_hit  [2];
  logic          cpu_done [2];
  logic          mem_req  [2];
  logic          mem_we   [2];
  logic [AW-1:0] mem_addr [2];
  logic [DW-1:0] mem_wdata[2];
  logic          mem_ack  [2];
  logic [DW-1:0] mem_rdata[2];

  // index 0: write-back, index 1: write-through
  cache2w_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(2), .WRITE_BACK(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
    .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_rdata(cpu_rdata[0]),
    .cpu_hit(cpu_hit[0]), .cpu_done(cpu_done[0]), .mem_req(mem_req[0]),
    .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]),
    .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  cache2w_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(2), .WRITE_BACK(1'b0)) dut_wt_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
    .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_rdata(cpu_rdata[1]),
    .cpu_hit(cpu_hit[1]), .cpu_done(cpu_done[1]), .mem_req(mem_req[1]),
    .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]),
    .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  // Backing memory models
  logic [DW-1:0] mem  [2][256];
  int            lat_cnt [2];
  int            ops_cnt [2];
  logic          first_we[2];

  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      mem_ack[m] <= 1'b0;
      if (!rst && mem_req[m] && !mem_ack[m]) begin
        if (lat_cnt[m] == LAT) begin
          lat_cnt[m] = 0;
          if (ops_cnt[m] == 0) first_we[m] = mem_we[m];
          ops_cnt[m] = ops_cnt[m] + 1;
          if (mem_we[m]) mem[m][mem_addr[m]] = mem_wdata[m];
          else mem_rdata[m] <= mem[m][mem_addr[m]];
          mem_ack[m] <= 1'b1;
        end else begin
          lat_cnt[m] = lat_cnt[m] + 1;
        end
      end
    end
  end

  // Reference model
  logic [DW-1:0] gm  [2][256];
  bit            rv  [2][2][2];
  bit            rd  [2][2][2];
  logic [AW-2:0] rt  [2][2][2];
  bit            rl  [2][2];

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int m = 0; m < 2; m++) begin
      cpu_req[m] = 0; cpu_we[m] = 0; cpu_addr[m] = '0; cpu_wdata[m] = '0;
      for (int s = 0; s < 2; s++) begin
        rl[m][s] = 0;
        for (int w = 0; w < 2; w++) begin rv[m][s][w] = 0; rd[m][s][w] = 0; end
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(!cpu_done[m] && !mem_req[m], "R1", {cpu_done[m], mem_req[m]}, 0);
    end
  endtask

  // One access; model predicts result; returns observed hit
  task automatic access(input int m, input logic [AW-1:0] a, input bit we,
                        input logic [DW-1:0] wd, output bit hit_o);
    bit            s, phit, pw, v, ev_dirty;
    logic [AW-1:0] ev_addr;
    logic [DW-1:0] mem_before, ev_val;
    int            to;
    s = a[0];
    phit = 0; pw = 0;
    for (int w = 0; w < 2; w++)
      if (rv[m][s][w] && rt[m][s][w] == a[AW-1:1]) begin phit = 1; pw = w[0]; end
    ev_dirty = 0; ev_addr = '0; ev_val = '0;
    if (!phit) begin
      v = !rv[m][s][0] ? 1'b0 : (!rv[m][s][1] ? 1'b1 : rl[m][s]);
      ev_dirty = (m == 0) && rv[m][s][v] && rd[m][s][v];
      ev_addr  = {rt[m][s][v], s};
      ev_val   = gm[m][ev_addr];
      rv[m][s][v] = 1; rt[m][s][v] = a[AW-1:1]; rd[m][s][v] = 0;
      pw = v;
    end
    rl[m][s] = ~pw;
    if (we) begin
      gm[m][a] = wd;
      if (m == 0) rd[m][s][pw] = 1;
    end
    mem_before = mem[m][a];
    ops_cnt[m] = 0;

    cpu_req[m] = 1; cpu_we[m] = we; cpu_addr[m] = a; cpu_wdata[m] = wd;
    @(negedge clk);
    cpu_req[m] = 0;
    to = 0;
    while (!cpu_done[m] && to < 200) begin @(negedge clk); to++; end
    check(to < 200, "R11", to, 200);
    hit_o = cpu_hit[m];
    check(cpu_hit[m] == phit, "R2", cpu_hit[m], phit);
    if (!we) check(cpu_rdata[m] == gm[m][a], "R3", cpu_rdata[m], gm[m][a]);
    if (!we && phit) check(ops_cnt[m] == 0, "R2", ops_cnt[m], 0);
    if (we && m == 1) check(mem[m][a] == wd, "R8", mem[m][a], wd);
    if (we && m == 0 && phit) check(mem[m][a] == mem_before, "R9", mem[m][a], mem_before);
    if (!phit && ev_dirty) begin
      check(ops_cnt[m] == 2 && first_we[m], "R9", {ops_cnt[m][7:0], 7'd0, first_we[m]}, 32'h201);
      check(mem[m][ev_addr] == ev_val, "R9", mem[m][ev_addr], ev_val);
    end
    if (!phit && !ev_dirty && !(we && m == 1))
      check(ops_cnt[m] == 1 && !first_we[m], "R10", ops_cnt[m], 1);
    @(negedge clk);
    check(!cpu_done[m], "R11", cpu_done[m], 0);
  endtask

  // Vector table: {reset_before, expected_hit, address}
  localparam logic [9:0] VEC [15] = '{
    {1'b1, 1'b0, 8'd0}, {1'b0, 1'b0, 8'd2}, {1'b0, 1'b1, 8'd0},
    {1'b0, 1'b0, 8'd4}, {1'b0, 1'b0, 8'd2},
    {1'b1, 1'b0, 8'd0}, {1'b0, 1'b0, 8'd2}, {1'b0, 1'b1, 8'd0},
    {1'b0, 1'b0, 8'd1}, {1'b0, 1'b0, 8'd4}, {1'b0, 1'b1, 8'd0},
    {1'b0, 1'b0, 8'd2}, {1'b0, 1'b0, 8'd3}, {1'b0, 1'b0, 8'd5},
    {1'b0, 1'b0, 8'd4}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit h;
    int hits;
    for (int m = 0; m < 2; m++) begin
      mem_ack[m] = 0; mem_rdata[m] = '0; lat_cnt[m] = 0; ops_cnt[m] = 0; first_we[m] = 0;
      for (int a = 0; a < 256; a++) begin
        mem[m][a] = 32'hA000_0000 | a;
        gm[m][a]  = 32'hA000_0000 | a;
      end
    end

    // R6, R7 sequences from the table, both policies
    for (int m = 0; m < 2; m++) begin
      hits = 0;
      for (int i = 0; i < 15; i++) begin
        if (VEC[i][9]) begin do_reset(); hits = 0; end
        access(m, VEC[i][7:0], 1'b0, '0, h);
        check(h == VEC[i][8], (i < 5) ? "R6" : "R7", h, VEC[i][8]);
        if (h) hits++;
      end
      check(hits == 2, "R7", hits, 2);
    end

    // R4/R5: fills use way 0 then way 1; LRU picks word 0 on third tag
    do_reset();
    access(0, 8'd0, 0, '0, h); check(!h, "R4", h, 0);
    access(0, 8'd2, 0, '0, h); check(!h, "R4", h, 0);
    access(0, 8'd0, 0, '0, h); check(h, "R5", h, 1);
    access(0, 8'd4, 0, '0, h); check(!h, "R5", h, 0);
    access(0, 8'd0, 0, '0, h); check(h, "R5", h, 1);   // word 2 was evicted
    access(0, 8'd2, 0, '0, h); check(!h, "R5", h, 0);

    // R9/R10/R12: write-back dirty eviction
    do_reset();
    access(0, 8'd0, 1, 32'h1111_0000, h); check(!h, "R12", h, 0);
    access(0, 8'd0, 0, '0, h);            check(h, "R12", h, 1);
    check(cpu_rdata[0] == 32'h1111_0000, "R12", cpu_rdata[0], 32'h1111_0000);
    access(0, 8'd0, 1, 32'h2222_0000, h); check(h, "R9", h, 1);
    access(0, 8'd2, 1, 32'h3333_0000, h);
    access(0, 8'd4, 0, '0, h);            // evicts dirty word 0
    check(mem[0][0] == 32'h2222_0000, "R9", mem[0][0], 32'h2222_0000);
    access(0, 8'd6, 0, '0, h);            // evicts dirty word 2
    check(mem[0][2] == 32'h3333_0000, "R9", mem[0][2], 32'h3333_0000);
    access(0, 8'd8, 0, '0, h);            // evicts clean word 4 (R10)
    access(0, 8'd1, 1, 32'h4444_0000, h); // other set untouched
    access(0, 8'd6, 0, '0, h);            check(h, "R2", h, 1);

    // R8: write-through hits and misses
    do_reset();
    access(1, 8'd0, 0, '0, h);
    access(1, 8'd0, 1, 32'h5555_0000, h); check(h, "R8", h, 1);
    access(1, 8'd2, 1, 32'h6666_0000, h); check(!h, "R8", h, 0);
    access(1, 8'd2, 0, '0, h);            check(h, "R12", h, 1);
    access(1, 8'd4, 0, '0, h);
    check(mem[1][0] == 32'h5555_0000, "R8", mem[1][0], 32'h5555_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule